// File: doc/BRIEF.md
# Floating-point operation-group dispatcher and result arbiter

This block sits at the top of a floating-point core that is split into four execution groups: fused and plain add/multiply, divide and square root, non-computational operations (sign injection, min/max, compare, classify), and conversions (float-to-int, int-to-float, float-to-float and the two cast-and-pack forms). It decodes the 4-bit operation code of each incoming request and offers it to exactly one group. It then collects the groups' result streams onto a single output port.

Both the request side and the result side are valid/ready streams. A request is offered only to the group its operation code selects. The block accepts the request in the cycle where that group's ready is high, so back-pressure from a busy group stalls the requester and no other group. The operand payload, tag and lane mask go to all groups unchanged. Only the selected group sees valid.

Results may finish out of order, so each one carries the tag its operation entered with. A round-robin arbiter picks among the groups presenting results. A group that is not granted keeps its result until it is. While the output is stalled, the granted result stays on the port unchanged. Per-lane status flags are OR-combined over the lanes whose mask bit is 1. A busy output reports that some group holds an operation.

Top module: `fpu_dispatch_arb`

## Requirements
- R1: Operation codes decode to groups as follows: 0 to 3 go to add/multiply (group 0), 4 and 5 go to divide/square-root (group 1), 6 to 9 go to non-computational (group 2), and 10 to 14 go to conversion (group 3).
- R2: While `in_valid` is high, exactly the decoded group's bit of `grp_valid` is high. While `in_valid` is low, `grp_valid` is all zero.
- R3: `in_ready` equals the `grp_ready` bit of the group that the current operation code decodes to.
- R4: `grp_payload`, `grp_tag`, `grp_lane_mask` and `grp_op` equal the request-side values in the same cycle, for every group.
- R5: After reset, group 0 has the highest priority. Priority then starts at the group after the last group whose result was transferred. `out_valid` is high exactly when some group presents a result or a stalled grant is pending.
- R6: If a group's result is transferred while another group is requesting, the next grant goes to a different group.
- R7: `res_ready` is high only for the granted group, and only while `out_ready` is high. Every other group sees ready low and holds its result.
- R8: While `out_valid` is high and `out_ready` is low, the grant does not change and the output fields stay stable. The priority pointer moves only on a completed transfer.
- R9: `out_result` and `out_tag` are the result and tag of the granted group.
- R10: `out_flags` (bit 4 invalid, bit 3 divide-by-zero, bit 2 overflow, bit 1 underflow, bit 0 inexact) is the OR of the granted group's per-lane flags over the lanes whose mask bit is 1. Lanes whose mask bit is 0 contribute nothing.
- R11: `busy` is high exactly when at least one bit of `grp_busy` is high.
- R12: The unused operation code 15 decodes to the non-computational group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_op | input | 4 | Operation code |
| in_payload | input | PAY_W | Operands and modifiers, passed through |
| in_tag | input | TAG_W | Operation tag |
| in_lane_mask | input | LANES | Per-lane flag mask |
| grp_valid | output | 4 | Request valid per group |
| grp_ready | input | 4 | Request ready per group |
| grp_op | output | 4 | Operation code to groups |
| grp_payload | output | PAY_W | Payload to groups |
| grp_tag | output | TAG_W | Tag to groups |
| grp_lane_mask | output | LANES | Lane mask to groups |
| grp_busy | input | 4 | Group holds an operation |
| res_valid | input | 4 | Result valid per group |
| res_ready | output | 4 | Result ready per group |
| res_data | input | 4 x RES_W | Result per group |
| res_tag | input | 4 x TAG_W | Returned tag per group |
| res_flags | input | 4 x LANES x 5 | Per-lane status flags per group |
| res_lane_mask | input | 4 x LANES | Returned lane mask per group |
| out_valid | output | 1 | Output result valid |
| out_ready | input | 1 | Output consumer ready |
| out_result | output | RES_W | Granted result |
| out_tag | output | TAG_W | Granted tag |
| out_flags | output | 5 | Masked, combined status flags |
| busy | output | 1 | Any group busy |

## Verification
The bench builds the block with four lanes, a 5-bit tag and narrow 24-bit payload and 20-bit result buses. This keeps the random tags and results distinct enough to expose a wrong mux selection, and makes partial lane masks common. Behavioural group stubs hold each result until it is taken. One phase drives all four groups and keeps the output ready, which shows the full rotation. A second phase holds `out_ready` low most of the time, so stalled grants and pointer freezing occur often. A third phase mixes sparse requests with new higher-priority arrivals during a stall.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  localparam int unsigned NUM_GRP  = 4;
  localparam int unsigned GRP_W    = $clog2(NUM_GRP);
  localparam int unsigned OP_W     = 4;
  localparam int unsigned FLAG_W   = 5;

  typedef enum logic [GRP_W-1:0] {
    GRP_ARITH   = 2'd0,
    GRP_DIVROOT = 2'd1,
    GRP_NONCOMP = 2'd2,
    GRP_CONVERT = 2'd3
  } grp_e;

  typedef enum logic [OP_W-1:0] {
    OPC_FMA     = 4'd0,
    OPC_FNMS    = 4'd1,
    OPC_ADD     = 4'd2,
    OPC_MUL     = 4'd3,
    OPC_DIV     = 4'd4,
    OPC_SQRT    = 4'd5,
    OPC_SGNJ    = 4'd6,
    OPC_MINMAX  = 4'd7,
    OPC_CMP     = 4'd8,
    OPC_CLASS   = 4'd9,
    OPC_F2F     = 4'd10,
    OPC_F2I     = 4'd11,
    OPC_I2F     = 4'd12,
    OPC_PACKLO  = 4'd13,
    OPC_PACKHI  = 4'd14,
    OPC_RSVD    = 4'd15
  } opc_e;
endpackage

// File: rtl/fpd_op_decode.sv
module fpd_op_decode
  import fpd_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output grp_e            grp
);
  always_comb begin
    unique case (opc_e'(op))
      OPC_FMA, OPC_FNMS, OPC_ADD, OPC_MUL:              grp = GRP_ARITH;
      OPC_DIV, OPC_SQRT:                                grp = GRP_DIVROOT;
      OPC_SGNJ, OPC_MINMAX, OPC_CMP, OPC_CLASS:         grp = GRP_NONCOMP;
      OPC_F2F, OPC_F2I, OPC_I2F, OPC_PACKLO, OPC_PACKHI: grp = GRP_CONVERT;
      default:                                          grp = GRP_NONCOMP; // R12
    endcase
  end
endmodule

// File: rtl/fpd_rr_arb.sv
module fpd_rr_arb #(
  parameter int unsigned N = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  input  logic                 take,
  output logic [N-1:0]         gnt,
  output logic [$clog2(N)-1:0] gnt_idx,
  output logic                 any
);
  localparam int unsigned IW = $clog2(N);

  logic [IW-1:0] last_q;
  logic          hold_q;
  logic [IW-1:0] hold_idx_q;
  logic [IW-1:0] pick;
  logic          found;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= int'(N); k++) begin
      int c;
      c = (int'(last_q) + k) % int'(N);
      if (!found && req[c]) begin
        found = 1'b1;
        pick  = IW'(c);
      end
    end
    if (hold_q) pick = hold_idx_q;
  end

  assign any     = hold_q | found;
  assign gnt_idx = pick;
  assign gnt     = any ? (N'(1) << pick) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q     <= IW'(N - 1);
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
    end else begin
      hold_q     <= any && !take;
      hold_idx_q <= pick;
      if (any && take) last_q <= pick;
    end
  end

  AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (gnt & req) != '0); // R5
  AST_FAIR_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    (any && take && ((req & ~gnt) != '0)) |=> (gnt != $past(gnt))); // R6
  AST_STALL_KEEPS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (any && !take) |=> (any && gnt == $past(gnt))); // R8
endmodule

// File: rtl/fpd_flag_merge.sv
module fpd_flag_merge
  import fpd_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic [LANES-1:0][FLAG_W-1:0] lane_flags,
  input  logic [LANES-1:0]             lane_mask,
  output logic [FLAG_W-1:0]            merged
);
  always_comb begin
    merged = '0;
    for (int l = 0; l < int'(LANES); l++) begin
      if (lane_mask[l]) merged = merged | lane_flags[l];
    end
  end
endmodule

// File: rtl/fpu_dispatch_arb.sv
module fpu_dispatch_arb
  import fpd_pkg::*;
#(
  parameter int unsigned PAY_W = 64,
  parameter int unsigned RES_W = 64,
  parameter int unsigned TAG_W = 4,
  parameter int unsigned LANES = 4
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    in_valid,
  output logic                                    in_ready,
  input  logic [OP_W-1:0]                         in_op,
  input  logic [PAY_W-1:0]                        in_payload,
  input  logic [TAG_W-1:0]                        in_tag,
  input  logic [LANES-1:0]                        in_lane_mask,
  output logic [NUM_GRP-1:0]                      grp_valid,
  input  logic [NUM_GRP-1:0]                      grp_ready,
  output logic [OP_W-1:0]                         grp_op,
  output logic [PAY_W-1:0]                        grp_payload,
  output logic [TAG_W-1:0]                        grp_tag,
  output logic [LANES-1:0]                        grp_lane_mask,
  input  logic [NUM_GRP-1:0]                      grp_busy,
  input  logic [NUM_GRP-1:0]                      res_valid,
  output logic [NUM_GRP-1:0]                      res_ready,
  input  logic [NUM_GRP-1:0][RES_W-1:0]           res_data,
  input  logic [NUM_GRP-1:0][TAG_W-1:0]           res_tag,
  input  logic [NUM_GRP-1:0][LANES-1:0][FLAG_W-1:0] res_flags,
  input  logic [NUM_GRP-1:0][LANES-1:0]           res_lane_mask,
  output logic                                    out_valid,
  input  logic                                    out_ready,
  output logic [RES_W-1:0]                        out_result,
  output logic [TAG_W-1:0]                        out_tag,
  output logic [FLAG_W-1:0]                       out_flags,
  output logic                                    busy
);
  grp_e             sel;
  logic [GRP_W-1:0] sel_idx;
  logic [NUM_GRP-1:0] gnt;
  logic [GRP_W-1:0]   gnt_idx;
  logic               gnt_any;

  fpd_op_decode u_decode (
    .op  (in_op),
    .grp (sel)
  );
  assign sel_idx = sel;

  // Request side: valid steered to one group, ready taken from it.
  generate
    for (genvar g = 0; g < int'(NUM_GRP); g++) begin : g_route
      assign grp_valid[g] = in_valid && (sel_idx == GRP_W'(g));
      assign res_ready[g] = gnt[g] && out_ready;
    end
  endgenerate

  assign in_ready      = grp_ready[sel_idx];
  assign grp_op        = in_op;
  assign grp_payload   = in_payload;
  assign grp_tag       = in_tag;
  assign grp_lane_mask = in_lane_mask;

  // Result side: fair arbitration and output mux.
  fpd_rr_arb #(.N(NUM_GRP)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (res_valid),
    .take    (out_ready),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .any     (gnt_any)
  );

  assign out_valid  = gnt_any;
  assign out_result = res_data[gnt_idx];
  assign out_tag    = res_tag[gnt_idx];

  fpd_flag_merge #(.LANES(LANES)) u_flags (
    .lane_flags (res_flags[gnt_idx]),
    .lane_mask  (res_lane_mask[gnt_idx]),
    .merged     (out_flags)
  );

  assign busy = |grp_busy;

  AST_ROUTE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_valid)); // R2
  AST_ACCEPT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> ((grp_valid & grp_ready) != '0)); // R3
  AST_RES_READY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_ready != '0) |-> ($onehot(res_ready) && out_valid && out_ready)); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_tag) && $stable(out_result))); // R8
endmodule

// File: tb/test_fpu_dispatch_arb.sv
module test_fpu_dispatch_arb;
  import fpd_pkg::*;
  localparam int PAY_W = 24;
  localparam int RES_W = 20;
  localparam int TAG_W = 5;
  localparam int LANES = 4;
  localparam int NG    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [3:0] in_op = '0;
  logic [PAY_W-1:0] in_payload = '0;
  logic [TAG_W-1:0] in_tag = '0;
  logic [LANES-1:0] in_lane_mask = '0;
  logic [NG-1:0] grp_valid, grp_ready = '0;
  logic [3:0] grp_op;
  logic [PAY_W-1:0] grp_payload;
  logic [TAG_W-1:0] grp_tag;
  logic [LANES-1:0] grp_lane_mask;
  logic [NG-1:0] grp_busy = '0;
  logic [NG-1:0] res_valid = '0, res_ready;
  logic [NG-1:0][RES_W-1:0] res_data = '0;
  logic [NG-1:0][TAG_W-1:0] res_tag = '0;
  logic [NG-1:0][LANES-1:0][4:0] res_flags = '0;
  logic [NG-1:0][LANES-1:0] res_lane_mask = '0;
  logic out_valid, out_ready = 1'b0;
  logic [RES_W-1:0] out_result;
  logic [TAG_W-1:0] out_tag;
  logic [4:0] out_flags;
  logic busy;

  int nvec = 0, nerr = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fpu_dispatch_arb #(.PAY_W(PAY_W), .RES_W(RES_W), .TAG_W(TAG_W), .LANES(LANES)) i_fpu_dispatch_arb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_payload(in_payload), .in_tag(in_tag), .in_lane_mask(in_lane_mask),
    .grp_valid(grp_valid), .grp_ready(grp_ready), .grp_op(grp_op), .grp_payload(grp_payload),
    .grp_tag(grp_tag), .grp_lane_mask(grp_lane_mask), .grp_busy(grp_busy),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data), .res_tag(res_tag),
    .res_flags(res_flags), .res_lane_mask(res_lane_mask), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_tag(out_tag), .out_flags(out_flags),
    .busy(busy));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int grp_of(logic [3:0] op);
    if (op <= 4'd3) return 0;      // R1
    if (op <= 4'd5) return 1;
    if (op <= 4'd9) return 2;
    if (op <= 4'd14) return 3;
    return 2;                      // R12
  endfunction

  // Reference model state
  int  last = NG - 1;
  bit  locked = 0;
  int  lock_idx = 0;
  bit  consumed [NG];
  bit  in_taken = 1;

  task automatic cycle(int mode);
    int eg, sg, c;
    logic [4:0] ef;
    @(posedge clk); #1;
    if (!in_valid || in_taken) begin
      in_valid     = (mode == 0) ? 1'b1 : 1'($urandom % 2);
      in_op        = 4'($urandom);
      in_payload   = PAY_W'($urandom);
      in_tag       = TAG_W'($urandom);
      in_lane_mask = LANES'($urandom);
    end
    grp_ready = NG'($urandom);
    grp_busy  = (mode == 2) ? NG'($urandom % 2) : NG'($urandom);
    for (int g = 0; g < NG; g++) begin
      if (!res_valid[g] || consumed[g]) begin
        res_valid[g]     = (mode == 0) ? 1'b1 : (mode == 2 ? ($urandom % 4 == 0) : ($urandom % 3 != 0));
        res_data[g]      = RES_W'($urandom);
        res_tag[g]       = TAG_W'($urandom);
        res_flags[g]     = (LANES*5)'($urandom);
        res_lane_mask[g] = LANES'($urandom);
      end
    end
    out_ready = (mode == 0) ? 1'b1 : (mode == 1 ? ($urandom % 4 == 0) : 1'($urandom % 2));
    #4;
    // expected grant
    eg = -1;
    if (locked) eg = lock_idx;
    else for (int k = 1; k <= NG; k++) begin
      c = (last + k) % NG;
      if (eg < 0 && res_valid[c]) eg = c;
    end
    chk(locked ? "R8 out_valid" : "R5 out_valid", 64'(out_valid), 64'(eg >= 0));
    if (eg >= 0) begin
      chk(locked ? "R8 out_tag" : "R6/R9 out_tag", 64'(out_tag), 64'(res_tag[eg]));
      chk("R9 out_result", 64'(out_result), 64'(res_data[eg]));
      ef = '0;
      for (int l = 0; l < LANES; l++) if (res_lane_mask[eg][l]) ef |= res_flags[eg][l];
      chk("R10 out_flags", 64'(out_flags), 64'(ef));
    end
    for (int g = 0; g < NG; g++)
      chk("R7 res_ready", 64'(res_ready[g]), 64'((g == eg) && out_ready));
    sg = grp_of(in_op);
    chk("R3 in_ready", 64'(in_ready), 64'(grp_ready[sg]));
    chk(in_op == 4'd15 ? "R12 grp_valid" : "R1/R2 grp_valid", 64'(grp_valid),
        in_valid ? 64'(1) << sg : 64'(0));
    chk("R4 grp_payload", 64'(grp_payload), 64'(in_payload));
    chk("R4 grp_tag", 64'({grp_op, grp_tag, grp_lane_mask}), 64'({in_op, in_tag, in_lane_mask}));
    chk("R11 busy", 64'(busy), 64'(grp_busy != '0));
    // model update for next edge
    for (int g = 0; g < NG; g++) consumed[g] = res_valid[g] && (g == eg) && out_ready;
    in_taken = in_valid && grp_ready[sg];
    if (eg >= 0) begin
      if (out_ready) begin last = eg; locked = 0; end
      else begin locked = 1; lock_idx = eg; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < NG; g++) consumed[g] = 0;
    repeat (3) @(posedge clk);
    #5;
    chk("R5 reset out_valid", 64'(out_valid), 64'(0));
    chk("R7 reset res_ready", 64'(res_ready), 64'(0));
    chk("R11 reset busy", 64'(busy), 64'(0));
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 400; i++) cycle(0);
    for (int i = 0; i < 1500; i++) cycle(1);
    for (int i = 0; i < 1500; i++) cycle(2);
    for (int i = 0; i < 600; i++) cycle(i % 3);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule